// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Software drives it through a small byte-wide register port. It enables the converter, picks the result alignment and sets a start bit. The sequencer then holds the sampled input. On each conversion-clock enable it settles one result bit, starting at the most significant bit. The trial code goes out on a DAC bus, and the comparator answer comes back on a single input.

At the end of a normal run, four things happen in the same cycle. The 16-bit result pair is written, the start bit drops, a sticky completion flag rises and the hold is released. If software clears the start bit before the end, the run is abandoned. The result pair keeps whatever it held before. A fixed guard wait of two conversion-clock enables follows before a new start is accepted. While the converter is switched off, the two result bytes work as ordinary read/write storage.

Top module: `sar_adc_seq`

## Requirements
- R1: With the format bit (control bit 2) at 1, a completed result r is stored right-aligned: high byte (address 1) = {6'b0, r[9:8]} and low byte (address 2) = r[7:0].
- R2: With the format bit at 0, a completed result r is stored left-aligned: high byte = r[9:2] and low byte = {r[1:0], 6'b0}.
- R3: Each run starts with `dac_code` = 10'h200. On each decision, the trial bit is kept when `cmp_in` is 1 (input at or above the DAC) and cleared otherwise, and the next lower bit becomes the new trial.
- R4: A run takes exactly 11 conversion-clock enables after the start: one setup enable, then ten bit decisions from bit 9 down to bit 0.
- R5: `hold` goes high in the cycle after an accepted start write and stays high until the run completes or is abandoned.
- R6: On completion, the result pair is loaded, the start bit (control bit 1) reads 0, `irq` goes to 1 and `hold` goes to 0, all in the same cycle.
- R7: The completion flag (control bit 3, driven on `irq`) is sticky. A control write with bit 3 = 1 leaves it unchanged, and one with bit 3 = 0 clears it. A completion in the same cycle as a clearing write leaves the flag at 1.
- R8: A control write with bit 1 = 0 during a run abandons it. Bit 0 = 0 (disable) abandons it too. Either way `hold` drops and the result pair keeps its earlier contents.
- R9: After a start-bit abandon, the sequencer waits 2 conversion-clock enables, and start writes during this wait are ignored. After the wait, a start write is accepted.
- R10: The result bytes can always be written by software and read back, including while the converter is off (control bit 0 = 0). A completion in the same cycle as a result-byte write overwrites that write.
- R11: A start bit in a write that also switches the converter on from off, or in a write while off, does not start a run.
- R12: `rd_data` shows, one cycle later, the register named by `rd_addr`. The control byte reads {4'b0, flag, format, start, enable}, and address 3 reads 0. After reset, every register and output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tad_tick | input | 1 | Conversion-clock enable, one pulse per conversion period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 result high, 2 result low |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC level |
| dac_code | output | 10 | Trial code for the DAC |
| hold | output | 1 | Sample/hold disconnect (1 = holding) |
| irq | output | 1 | Sticky completion flag |

## Verification
Two pairs of events can land on the last bit decision. One is a completion together with a software write that clears the completion flag. The other is a completion together with a software write to the low result byte. The bench provokes each by driving the conversion-clock enable by hand. It issues ten enables, then puts the eleventh in the same cycle as the write. It then judges that the flag stays set and that the low byte holds the converted value rather than the written one. A behavioural model, updated on every edge, checks the DAC code, hold, flag and read data in every cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_SETUP = 3'd2,
    ST_CONV  = 3'd3,
    ST_WAIT  = 3'd4
  } sar_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_LO   = 2'd2;

  localparam int BIT_EN   = 0;
  localparam int BIT_GO   = 1;
  localparam int BIT_FMT  = 2;
  localparam int BIT_FLAG = 3;
endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int SETUP_TICKS = 1,
  parameter int ABORT_TICKS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       ctrl_wr,
  input  logic                       wd_en,
  input  logic                       wd_go,
  output sar_state_e                 state,
  output logic [$clog2(RES_W)-1:0]   idx,
  output logic                       start,
  output logic                       step,
  output logic                       finish,
  output logic                       busy,
  output logic                       hold
);
  localparam int IDX_W   = $clog2(RES_W);
  localparam int CNT_MAX = (SETUP_TICKS > ABORT_TICKS) ? SETUP_TICKS : ABORT_TICKS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  sar_state_e       state_d;
  logic [CNT_W-1:0] cnt;
  logic             kill, stop_wr, setup_done, wait_done;

  assign busy       = (state == ST_SETUP) || (state == ST_CONV);
  assign kill       = ctrl_wr && !wd_en;
  assign stop_wr    = ctrl_wr && busy && (!wd_go || !wd_en);
  assign start      = ctrl_wr && (state == ST_IDLE) && wd_en && wd_go;
  assign step       = (state == ST_CONV) && tick && !stop_wr;
  assign finish     = step && (idx == '0);
  assign setup_done = (state == ST_SETUP) && tick && !stop_wr &&
                      (cnt == CNT_W'(SETUP_TICKS - 1));
  assign wait_done  = (state == ST_WAIT) && tick && (cnt == CNT_W'(ABORT_TICKS - 1));

  always_comb begin
    state_d = state;
    case (state)
      ST_OFF:   if (ctrl_wr && wd_en) state_d = ST_IDLE;
      ST_IDLE:  if (kill) state_d = ST_OFF;
                else if (start) state_d = ST_SETUP;
      ST_SETUP: if (kill) state_d = ST_OFF;
                else if (stop_wr) state_d = ST_WAIT;
                else if (setup_done) state_d = ST_CONV;
      ST_CONV:  if (kill) state_d = ST_OFF;
                else if (stop_wr) state_d = ST_WAIT;
                else if (finish) state_d = ST_IDLE;
      ST_WAIT:  if (kill) state_d = ST_OFF;
                else if (wait_done) state_d = ST_IDLE;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OFF;
      cnt   <= '0;
      idx   <= '0;
      hold  <= 1'b0;
    end else begin
      state <= state_d;
      hold  <= (state_d == ST_SETUP) || (state_d == ST_CONV);
      if (state_d != state)
        cnt <= '0;
      else if (tick && ((state == ST_SETUP) || (state == ST_WAIT)))
        cnt <= cnt + 1'b1;
      if (setup_done)
        idx <= IDX_W'(RES_W - 1);
      else if (step && (idx != '0))
        idx <= idx - 1'b1;
    end
  end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     step,
  input  logic [$clog2(RES_W)-1:0] idx,
  input  logic                     cmp,
  output logic [RES_W-1:0]         trial,
  output logic [RES_W-1:0]         decided
);
  logic [RES_W-1:0] mask, next_trial;

  assign mask    = RES_W'(1) << idx;
  assign decided = cmp ? (trial | mask) : (trial & ~mask);
  assign next_trial = decided | ((idx != '0) ? (mask >> 1) : '0);

  always_ff @(posedge clk) begin
    if (rst)
      trial <= '0;
    else if (start)
      trial <= RES_W'(1) << (RES_W - 1);
    else if (step)
      trial <= next_trial;
  end
endmodule

// File: rtl/sar_regfile.sv
module sar_regfile
  import sar_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  input  logic             finish,
  input  logic             busy,
  input  logic [RES_W-1:0] result,
  output logic             flag,
  output logic [REG_W-1:0] res_hi,
  output logic [REG_W-1:0] res_lo,
  output logic [REG_W-1:0] rd_data
);
  localparam int PAIR_W = 2 * REG_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic              en, fmt;
  logic [PAIR_W-1:0] wide, placed;
  logic [REG_W-1:0]  ctrl_word, rd_mux;

  assign wide   = PAIR_W'(result);
  assign placed = fmt ? wide : (wide << PAD_W);

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[BIT_EN]   = en;
    ctrl_word[BIT_GO]   = busy;
    ctrl_word[BIT_FMT]  = fmt;
    ctrl_word[BIT_FLAG] = flag;
    case (rd_addr)
      ADDR_CTRL: rd_mux = ctrl_word;
      ADDR_HI:   rd_mux = res_hi;
      ADDR_LO:   rd_mux = res_lo;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      fmt     <= 1'b0;
      flag    <= 1'b0;
      res_hi  <= '0;
      res_lo  <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= rd_mux;
      if (wr_en && wr_addr == ADDR_CTRL) begin
        en  <= wr_data[BIT_EN];
        fmt <= wr_data[BIT_FMT];
      end
      if (finish)
        flag <= 1'b1;
      else if (wr_en && wr_addr == ADDR_CTRL && !wr_data[BIT_FLAG])
        flag <= 1'b0;
      if (finish) begin
        res_hi <= placed[PAIR_W-1:REG_W];
        res_lo <= placed[REG_W-1:0];
      end else if (wr_en) begin
        if (wr_addr == ADDR_HI) res_hi <= wr_data;
        if (wr_addr == ADDR_LO) res_lo <= wr_data;
      end
    end
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int REG_W       = 8,
  parameter int SETUP_TICKS = 1,
  parameter int ABORT_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tad_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             hold,
  output logic             irq
);
  localparam int IDX_W = $clog2(RES_W);

  sar_state_e       state;
  logic [IDX_W-1:0] idx;
  logic             start, step, finish, busy, ctrl_wr;
  logic [RES_W-1:0] decided;
  logic [REG_W-1:0] res_hi, res_lo;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  sar_seq_fsm #(
    .RES_W(RES_W), .SETUP_TICKS(SETUP_TICKS), .ABORT_TICKS(ABORT_TICKS)
  ) u_fsm (
    .clk(clk), .rst(rst), .tick(tad_tick), .ctrl_wr(ctrl_wr),
    .wd_en(wr_data[BIT_EN]), .wd_go(wr_data[BIT_GO]),
    .state(state), .idx(idx), .start(start), .step(step),
    .finish(finish), .busy(busy), .hold(hold)
  );

  sar_approx #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst(rst), .start(start), .step(step), .idx(idx),
    .cmp(cmp_in), .trial(dac_code), .decided(decided)
  );

  sar_regfile #(.RES_W(RES_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .finish(finish), .busy(busy),
    .result(decided), .flag(irq), .res_hi(res_hi), .res_lo(res_lo),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk
  import sar_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int REG_W       = 8,
  parameter int ABORT_TICKS = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             tad_tick,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [REG_W-1:0] wr_data,
  input logic [RES_W-1:0] dac_code,
  input logic             hold,
  input logic             irq,
  input sar_state_e       state,
  input logic [REG_W-1:0] res_hi,
  input logic [REG_W-1:0] res_lo
);
  localparam int WC_W = $clog2(ABORT_TICKS + 1);
  logic [WC_W-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst || state != ST_WAIT) wcnt <= '0;
    else if (tad_tick) wcnt <= wcnt + 1'b1;
  end

  assert_start_code_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> dac_code == (RES_W'(1) << (RES_W - 1)));

  assert_hold_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $past(wr_en && wr_addr == ADDR_CTRL && wr_data[BIT_GO] && wr_data[BIT_EN]));

  assert_done_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $fell(hold));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(wr_en && wr_addr == ADDR_CTRL && !wr_data[BIT_FLAG]));

  assert_abort_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && $past(state) == ST_CONV) |-> ($stable(res_hi) && $stable(res_lo)));

  assert_guard_wait_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_WAIT) |->
      ($past(tad_tick) && $past(wcnt) == WC_W'(ABORT_TICKS - 1)));
endmodule

bind sar_adc_seq sar_adc_seq_chk #(
  .RES_W(RES_W), .REG_W(REG_W), .ABORT_TICKS(ABORT_TICKS)
) u_chk (
  .clk(clk), .rst(rst), .tad_tick(tad_tick), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .dac_code(dac_code),
  .hold(hold), .irq(irq), .state(state), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/tb_sar_adc_seq.sv
`timescale 1ns/1ps
module tb_sar_adc_seq;
  localparam int SETUP_T = 1;
  localparam int ABORT_T = 2;

  logic       clk = 0;
  logic       rst = 1;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic [9:0] dac_code;
  logic       hold, irq, cmp_in;
  logic [9:0] ain = 0;
  logic       auto_tk = 0, auto_ph = 0, man_tk = 0, tad_tick;
  int         cyc = 0, errors = 0, checks = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  assign cmp_in   = (ain >= dac_code);
  assign tad_tick = auto_tk ? auto_ph : man_tk;

  sar_adc_seq dut (
    .clk(clk), .rst(rst), .tad_tick(tad_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .cmp_in(cmp_in), .dac_code(dac_code),
    .hold(hold), .irq(irq)
  );

  always @(negedge clk) begin
    cyc++;
    auto_ph <= (cyc % 4 == 3);
  end

  // behavioural reference model
  logic       m_en, m_fmt, m_flag, m_hold, m_fin;
  logic [7:0] m_hi, m_lo, m_rd;
  logic [9:0] m_sar;
  logic [15:0] m_pl;
  int         m_ph, m_nph, m_cnt, m_idx;
  logic       m_cw, m_bz;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_fmt = 0; m_flag = 0; m_hold = 0; m_hi = 0; m_lo = 0;
      m_rd = 0; m_sar = 0; m_ph = 0; m_cnt = 0; m_idx = 0;
    end else begin
      m_cw = wr_en && wr_addr == 2'd0;
      m_bz = (m_ph == 2 || m_ph == 3);
      case (rd_addr)
        2'd0: m_rd = {4'b0, m_flag, m_fmt, m_bz, m_en};
        2'd1: m_rd = m_hi;
        2'd2: m_rd = m_lo;
        default: m_rd = 0;
      endcase
      m_fin = 0;
      m_nph = m_ph;
      if (m_ph != 0 && m_cw && !wr_data[0]) m_nph = 0;
      else case (m_ph)
        0: if (m_cw && wr_data[0]) m_nph = 1;
        1: if (m_cw && wr_data[1]) begin m_nph = 2; m_sar = 10'h200; end
        2: if (m_cw && !wr_data[1]) m_nph = 4;
           else if (tad_tick) begin
             if (m_cnt == SETUP_T - 1) begin m_nph = 3; m_idx = 9; end
             else m_cnt++;
           end
        3: if (m_cw && !wr_data[1]) m_nph = 4;
           else if (tad_tick) begin
             if (!(ain >= m_sar)) m_sar[m_idx] = 0;
             if (m_idx == 0) begin m_fin = 1; m_nph = 1; end
             else begin m_sar[m_idx-1] = 1; m_idx--; end
           end
        4: if (tad_tick) begin
             if (m_cnt == ABORT_T - 1) m_nph = 1; else m_cnt++;
           end
        default: m_nph = 0;
      endcase
      if (m_nph != m_ph) m_cnt = 0;
      if (wr_en && wr_addr == 2'd1) m_hi = wr_data;
      if (wr_en && wr_addr == 2'd2) m_lo = wr_data;
      if (m_cw && !wr_data[3]) m_flag = 0;
      if (m_fin) begin
        m_pl = m_fmt ? {6'b0, m_sar} : {m_sar, 6'b0};
        m_hi = m_pl[15:8]; m_lo = m_pl[7:0]; m_flag = 1;
      end
      if (m_cw) begin m_en = wr_data[0]; m_fmt = wr_data[2]; end
      m_ph = m_nph;
      m_hold = (m_ph == 2 || m_ph == 3);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R3 dac_code vs model", dac_code, m_sar);
    chk("R5 hold vs model", hold, m_hold);
    chk("R7 irq vs model", irq, m_flag);
    chk("R12 rd_data vs model", rd_data, m_rd);
  end

  task automatic cyc1; @(posedge clk); @(negedge clk); endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; cyc1; wr_en = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a; cyc1; v = rd_data;
  endtask
  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin man_tk = 1; cyc1; man_tk = 0; cyc1; end
  endtask
  task automatic wait_irq;
    for (int i = 0; i < 400 && !irq; i++) cyc1;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [9:0] vals [3];
    vals[0] = 10'h3FF; vals[1] = 10'h000; vals[2] = 10'h155;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0; cyc1;
    // R12 reset state and address 3
    rd(2'd0, v); chk("R12 ctrl after reset", v, 0);
    rd(2'd3, v); chk("R12 addr3 reads zero", v, 0);
    chk("R12 irq after reset", irq, 0);
    // R10 storage while off
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    rd(2'd1, v); chk("R10 hi storage off", v, 8'hA5);
    rd(2'd2, v); chk("R10 lo storage off", v, 8'h3C);
    // R11 go in enabling write
    wr(2'd0, 8'h03);
    chk("R11 no hold on enabling go", hold, 0);
    rd(2'd0, v); chk("R11 ctrl go stays 0", v, 8'h01);
    // R1 R4 R5 R6 manual ticks, right aligned
    ain = 10'h2B7;
    wr(2'd0, 8'h07);
    chk("R5 hold after start", hold, 1);
    chk("R3 first trial", dac_code, 10'h200);
    pulse(10);
    chk("R4 still busy after 10 ticks", hold, 1);
    chk("R4 no irq after 10 ticks", irq, 0);
    pulse(1);
    chk("R6 irq on completion", irq, 1);
    chk("R6 hold released", hold, 0);
    rd(2'd0, v); chk("R6 ctrl go cleared", v, 8'h0D);
    rd(2'd1, v); chk("R1 hi right aligned", v, 8'h02);
    rd(2'd2, v); chk("R1 lo right aligned", v, 8'hB7);
    // R7 sticky
    wr(2'd0, 8'h0D); chk("R7 write 1 keeps flag", irq, 1);
    wr(2'd0, 8'h05); chk("R7 write 0 clears flag", irq, 0);
    // R2 left aligned, several inputs
    auto_tk = 1;
    foreach (vals[k]) begin
      ain = vals[k];
      wr(2'd0, 8'h03); wait_irq; cyc1;
      rd(2'd1, v); chk("R2 hi left aligned", v, ain[9:2]);
      rd(2'd2, v); chk("R2 lo left aligned", v, {ain[1:0], 6'b0});
      wr(2'd0, 8'h01);
    end
    // R8 abort keeps result (last was 0x155 left)
    auto_tk = 0;
    ain = 10'h123;
    wr(2'd0, 8'h03); pulse(5);
    wr(2'd0, 8'h01);
    chk("R8 hold drops on abort", hold, 0);
    rd(2'd1, v); chk("R8 hi kept", v, 8'h55);
    rd(2'd2, v); chk("R8 lo kept", v, 8'h40);
    // R9 guard wait
    wr(2'd0, 8'h03); chk("R9 start ignored in wait 0", hold, 0);
    pulse(1);
    wr(2'd0, 8'h03); chk("R9 start ignored in wait 1", hold, 0);
    pulse(1);
    wr(2'd0, 8'h03); chk("R9 start accepted after wait", hold, 1);
    pulse(11);
    rd(2'd1, v); chk("R9 run after wait hi", v, 8'h48);
    rd(2'd2, v); chk("R9 run after wait lo", v, 8'hC0);
    // R7 coincidence: completion with clearing write
    ain = 10'h0F0;
    wr(2'd0, 8'h0B); pulse(10);
    man_tk = 1; wr(2'd0, 8'h03); man_tk = 0;
    chk("R7 completion beats clear", irq, 1);
    rd(2'd1, v); chk("R7 coincident result hi", v, 8'h3C);
    // R10 coincidence: completion with result write
    wr(2'd0, 8'h01);
    ain = 10'h155;
    wr(2'd0, 8'h03); pulse(10);
    man_tk = 1; wr(2'd2, 8'hEE); man_tk = 0;
    rd(2'd2, v); chk("R10 completion beats lo write", v, 8'h40);
    rd(2'd1, v); chk("R10 coincident hi", v, 8'h55);
    wr(2'd2, 8'h99); rd(2'd2, v); chk("R10 lo write while idle", v, 8'h99);
    // R8 disable mid run
    wr(2'd0, 8'h03); pulse(3);
    wr(2'd0, 8'h00);
    chk("R8 hold drops on disable", hold, 0);
    rd(2'd2, v); chk("R8 lo kept on disable", v, 8'h99);
    wr(2'd0, 8'h02); chk("R11 go while off ignored", hold, 0);
    cyc1;
    finish_run();
  end
endmodule